// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous dynamic RAM alive. It owns the power-up ritual. After reset it holds both strobes high for a long settling pause. It then issues a fixed number of dummy row-strobe pulses with the column strobe held high. Only after that does it hand the memory to the access controller. In normal operation a period timer owes one CAS-before-RAS (CBR) refresh at even intervals, so that every row is covered within the retention interval. Owed refreshes are counted, and the block raises a request. It drives the strobes only after the access controller grants the bus.

Strobe sharing uses one ownership output. While it is high, the board-level mux routes this block's row and column strobes to the memory. Both byte column strobes are tied to the single column strobe output. The address lines are not driven, because a CBR cycle ignores them.

A level sleep input moves the memory into self-refresh once granted. The block enters with a CBR cycle and then holds both strobes low for at least a minimum time. When sleep falls, the block raises the row strobe for an exit recovery time. It then performs one mandatory CBR refresh before it gives the bus back.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is applied, and for PAUSE_CYC clock cycles after it is released, `busy`=1 and `own`=1, both strobes are high (`ras_n`=1, `cas_n`=1), `req`=0 and `self_ref`=0.
- R2: After the pause, INIT_CYCLES dummy pulses follow. Each pulse holds `ras_n` low for RAS_CYC cycles and then high for RP_CYC cycles, with `cas_n` high throughout. `busy` falls in the cycle after the last high phase.
- R3: `req` is never high while `busy` is high. `own` falls together with `busy`.
- R4: Once `busy` has fallen, one refresh becomes owed every RFSH_CYC cycles. The first owed refresh raises `req` exactly RFSH_CYC cycles after the first cycle with `busy`=0.
- R5: While `req`=1 and `grant`=0, `own` stays 0 and both strobes stay high. A cycle starts (own rises) only in the cycle after one in which `req` and `grant` were both high.
- R6: A refresh cycle is, in order: CSR_CYC cycles with `cas_n`=0 and `ras_n`=1, then RAS_CYC cycles with both low, then RP_CYC cycles with both high. `own` is 1 across all three phases and falls after them.
- R7: The count of owed refreshes saturates at PEND_MAX. With `grant` held high, each refresh cycle retires one owed refresh, and cycles run back to back until the count is zero. `req` is 0 in the first idle cycle after the last one.
- R8: A granted request with `sleep`=1 produces a CSR_CYC-cycle column-first phase. A hold phase follows with both strobes low and `self_ref`=1. The hold lasts SR_MIN_CYC cycles if `sleep` falls earlier. Otherwise it lasts until the first clock edge that samples `sleep`=0.
- R9: Leaving the hold raises `ras_n` and `cas_n` for SR_EXIT_CYC cycles. Exactly one R6-shaped refresh follows before `own` falls.
- R10: Sleep takes priority over owed refreshes, and entering self-refresh clears the owed count. If `sleep` has dropped, `req` is 0 after the exit refresh, even when refreshes were owed at entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Access controller hands the strobes to this block |
| sleep | input | 1 | Level request to enter and stay in self-refresh |
| req | output | 1 | Block needs the strobes (owed refresh or sleep) |
| own | output | 1 | Block is driving the strobes; selects the strobe mux |
| busy | output | 1 | Power-up pause or dummy pulses in progress; accesses blocked |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe for both bytes, active low |
| self_ref | output | 1 | Memory is held in self-refresh |

## Verification
All strobe and status outputs are Moore outputs of one state register. Each therefore changes one clock edge after the edge that accepts a grant or that closes a timed phase, and phase lengths come out as exact cycle counts. `req` alone is combinational: it follows `sleep` in the same cycle, and it follows an owed-refresh tick one edge after the timer expires. The bench samples every output at the falling clock edge. It compresses the strobe/status vector into runs and compares each run's value and length with the expected segments queued ahead of time. Only idle runs, whose length depends on grant timing, are left unchecked. Timing of `req` is checked by counting falling-edge samples from the first non-busy cycle. The sleep input is dropped at a counted hold sample, so both hold-length cases of R8 are exact.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_WARM_LO,
        ST_WARM_HI,
        ST_IDLE,
        ST_RF_CAS,
        ST_RF_RAS,
        ST_RF_PRE,
        ST_SL_CAS,
        ST_SL_HOLD,
        ST_SL_EXIT
    } seq_st_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_period_timer.sv
module rfsh_period_timer #(
    parameter int unsigned PERIOD_CYC = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int W = $clog2(PERIOD_CYC + 1);
    localparam logic [W-1:0] RELOAD = W'(PERIOD_CYC - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    // Down-counter held at its reload value while not running.
    always_comb begin
        t_d    = t_q;
        tick_o = run_i && (t_q.cnt == '0);
        if (!run_i || t_q.cnt == '0) begin
            t_d.cnt = RELOAD;
        end else begin
            t_d.cnt = t_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt <= RELOAD;
        end else begin
            t_q <= t_d;
        end
    end

    generate
        if (PERIOD_CYC > 1) begin : g_gap
            // R4: owed refreshes are spaced, never two in adjacent cycles
            p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/rfsh_pend_ctr.sv
module rfsh_pend_ctr #(
    parameter int unsigned PEND_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic retire_i,
    input  logic clear_i,
    output logic has_o
);
    localparam int W = $clog2(PEND_MAX + 1);
    localparam logic [W-1:0] TOP = W'(PEND_MAX);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pend_t;

    pend_t p_d, p_q;
    logic  up, dn;

    always_comb begin
        p_d   = p_q;
        up    = tick_i;
        dn    = retire_i && (p_q.cnt != '0);
        has_o = (p_q.cnt != '0);
        if (clear_i) begin
            p_d.cnt = '0;
        end else if (up && !dn && p_q.cnt != TOP) begin
            p_d.cnt = p_q.cnt + W'(1);
        end else if (dn && !up) begin
            p_d.cnt = p_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.cnt <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    // R7: a full count absorbs further ticks without wrapping
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.cnt == TOP && tick_i && !retire_i && !clear_i) |=> (p_q.cnt == TOP));

    // R7: a retired refresh lowers the count by exactly one
    p_retire_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.cnt != '0 && retire_i && !tick_i && !clear_i) |=> (p_q.cnt == $past(p_q.cnt) - W'(1)));

    // R10: entering self-refresh leaves nothing owed
    p_clear_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !has_o);

endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC   = 20_000_000,
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned CSR_CYC     = 2,
    parameter int unsigned RAS_CYC     = 5,
    parameter int unsigned RP_CYC      = 3,
    parameter int unsigned SR_MIN_CYC  = 10_000_000,
    parameter int unsigned SR_EXIT_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    input  logic sleep_i,
    input  logic pend_i,
    output logic req_o,
    output logic own_o,
    output logic busy_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic sr_o,
    output logic run_o,
    output logic retire_o,
    output logic clear_o
);
    localparam int unsigned SPAN =
        max2(max2(max2(PAUSE_CYC, SR_MIN_CYC), max2(RAS_CYC, RP_CYC)),
             max2(CSR_CYC, SR_EXIT_CYC));
    localparam int CNT_W  = $clog2(SPAN + 1);
    localparam int LEFT_W = $clog2(INIT_CYCLES + 1);

    localparam logic [CNT_W-1:0]  PAUSE_LD = CNT_W'(PAUSE_CYC);
    localparam logic [CNT_W-1:0]  CSR_LD   = CNT_W'(CSR_CYC - 1);
    localparam logic [CNT_W-1:0]  RAS_LD   = CNT_W'(RAS_CYC - 1);
    localparam logic [CNT_W-1:0]  RP_LD    = CNT_W'(RP_CYC - 1);
    localparam logic [CNT_W-1:0]  HOLD_LD  = CNT_W'(SR_MIN_CYC - 1);
    localparam logic [CNT_W-1:0]  EXIT_LD  = CNT_W'(SR_EXIT_CYC - 1);
    localparam logic [LEFT_W-1:0] LEFT_LD  = LEFT_W'(INIT_CYCLES);

    typedef struct packed {
        seq_st_e            st;
        logic [CNT_W-1:0]   cnt;
        logic [LEFT_W-1:0]  left;
    } fsm_t;

    fsm_t r_d, r_q;
    logic done;

    // Next-state computation: each timed phase loads cnt with length-1.
    always_comb begin
        r_d      = r_q;
        done     = (r_q.cnt == '0);
        req_o    = (r_q.st == ST_IDLE) && (pend_i || sleep_i);
        retire_o = 1'b0;
        clear_o  = 1'b0;
        if (!done && r_q.st != ST_IDLE) begin
            r_d.cnt = r_q.cnt - CNT_W'(1);
        end
        unique case (r_q.st)
            ST_PAUSE: if (done) begin
                r_d.st  = ST_WARM_LO;
                r_d.cnt = RAS_LD;
            end
            ST_WARM_LO: if (done) begin
                r_d.st  = ST_WARM_HI;
                r_d.cnt = RP_LD;
            end
            ST_WARM_HI: if (done) begin
                if (r_q.left == LEFT_W'(1)) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.st   = ST_WARM_LO;
                    r_d.cnt  = RAS_LD;
                    r_d.left = r_q.left - LEFT_W'(1);
                end
            end
            ST_IDLE: if (req_o && grant_i) begin
                r_d.cnt = CSR_LD;
                if (sleep_i) begin
                    r_d.st  = ST_SL_CAS;
                    clear_o = 1'b1;
                end else begin
                    r_d.st = ST_RF_CAS;
                end
            end
            ST_RF_CAS: if (done) begin
                r_d.st  = ST_RF_RAS;
                r_d.cnt = RAS_LD;
            end
            ST_RF_RAS: if (done) begin
                r_d.st  = ST_RF_PRE;
                r_d.cnt = RP_LD;
            end
            ST_RF_PRE: if (done) begin
                r_d.st   = ST_IDLE;
                retire_o = 1'b1;
            end
            ST_SL_CAS: if (done) begin
                r_d.st  = ST_SL_HOLD;
                r_d.cnt = HOLD_LD;
            end
            ST_SL_HOLD: if (done && !sleep_i) begin
                r_d.st  = ST_SL_EXIT;
                r_d.cnt = EXIT_LD;
            end
            ST_SL_EXIT: if (done) begin
                r_d.st  = ST_RF_CAS;
                r_d.cnt = CSR_LD;
            end
            default: r_d.st = ST_PAUSE;
        endcase
    end

    // Moore decode of the strobes and status.
    always_comb begin
        own_o   = 1'b1;
        busy_o  = 1'b0;
        ras_n_o = 1'b1;
        cas_n_o = 1'b1;
        sr_o    = 1'b0;
        run_o   = 1'b0;
        unique case (r_q.st)
            ST_PAUSE, ST_WARM_HI: busy_o = 1'b1;
            ST_WARM_LO: begin
                busy_o  = 1'b1;
                ras_n_o = 1'b0;
            end
            ST_IDLE: begin
                own_o = 1'b0;
                run_o = 1'b1;
            end
            ST_RF_CAS: begin
                cas_n_o = 1'b0;
                run_o   = 1'b1;
            end
            ST_RF_RAS: begin
                cas_n_o = 1'b0;
                ras_n_o = 1'b0;
                run_o   = 1'b1;
            end
            ST_RF_PRE: run_o = 1'b1;
            ST_SL_CAS: cas_n_o = 1'b0;
            ST_SL_HOLD: begin
                cas_n_o = 1'b0;
                ras_n_o = 1'b0;
                sr_o    = 1'b1;
            end
            ST_SL_EXIT: ;
            default: busy_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_PAUSE;
            r_q.cnt  <= PAUSE_LD;
            r_q.left <= LEFT_LD;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: dummy pulses never lower the column strobe
    p_busy_cas_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> cas_n_o);

    // R3: no request to the access controller during initialization
    p_busy_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !req_o);

    // R5: the strobes are taken only after a granted request
    p_own_on_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $rose(own_o)) |-> $past(grant_i && req_o));

    // R6: outside initialization the column strobe always leads the row strobe
    p_cas_leads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $fell(ras_n_o)) |-> $past(!cas_n_o));

    // R8: self-refresh holds both strobes low while owned
    p_sr_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_o |-> (!ras_n_o && !cas_n_o && own_o));

    // R9: leaving self-refresh raises the row strobe and keeps the bus
    p_sr_exit_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_o) |-> (ras_n_o && own_o));

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq #(
    parameter int unsigned PAUSE_CYC   = 20_000_000,
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned RFSH_CYC    = 1562,
    parameter int unsigned PEND_MAX    = 4,
    parameter int unsigned CSR_CYC     = 2,
    parameter int unsigned RAS_CYC     = 5,
    parameter int unsigned RP_CYC      = 3,
    parameter int unsigned SR_MIN_CYC  = 10_000_000,
    parameter int unsigned SR_EXIT_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic sleep,
    output logic req,
    output logic own,
    output logic busy,
    output logic ras_n,
    output logic cas_n,
    output logic self_ref
);
    logic tmr_run, tmr_tick;
    logic pend_has, pend_retire, pend_clear;

    rfsh_period_timer #(
        .PERIOD_CYC (RFSH_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (tmr_run),
        .tick_o (tmr_tick)
    );

    rfsh_pend_ctr #(
        .PEND_MAX (PEND_MAX)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tmr_tick),
        .retire_i (pend_retire),
        .clear_i  (pend_clear),
        .has_o    (pend_has)
    );

    rfsh_seq_fsm #(
        .PAUSE_CYC   (PAUSE_CYC),
        .INIT_CYCLES (INIT_CYCLES),
        .CSR_CYC     (CSR_CYC),
        .RAS_CYC     (RAS_CYC),
        .RP_CYC      (RP_CYC),
        .SR_MIN_CYC  (SR_MIN_CYC),
        .SR_EXIT_CYC (SR_EXIT_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant_i  (grant),
        .sleep_i  (sleep),
        .pend_i   (pend_has),
        .req_o    (req),
        .own_o    (own),
        .busy_o   (busy),
        .ras_n_o  (ras_n),
        .cas_n_o  (cas_n),
        .sr_o     (self_ref),
        .run_o    (tmr_run),
        .retire_o (pend_retire),
        .clear_o  (pend_clear)
    );

endmodule

// File: tb/sim_dram_rfsh_seq.sv
module sim_dram_rfsh_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PAUSE  = 20;
    localparam int INIT   = 8;
    localparam int RFSH   = 60;
    localparam int PMAX   = 3;
    localparam int CSR    = 2;
    localparam int RAS    = 3;
    localparam int RP     = 2;
    localparam int SRMIN  = 10;
    localparam int SREXIT = 4;
    localparam int WD_CYC = 20000;

    // vector order: {own, busy, ras_n, cas_n, self_ref}
    localparam logic [4:0] V_PAUSE = 5'b11110;
    localparam logic [4:0] V_WLO   = 5'b11010;
    localparam logic [4:0] V_IDLE  = 5'b00110;
    localparam logic [4:0] V_CAS   = 5'b10100;
    localparam logic [4:0] V_RAS   = 5'b10000;
    localparam logic [4:0] V_PRE   = 5'b10110;
    localparam logic [4:0] V_HOLD  = 5'b10001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b0;
    logic sleep = 1'b0;
    logic req, own, busy, ras_n, cas_n, self_ref;

    typedef struct {
        logic [4:0] vec;
        int         len;
        string      tag;
    } seg_t;

    seg_t       exp_q[$];
    int         checks = 0;
    int         fails = 0;
    int         n = 0;
    logic [4:0] cur_vec;
    int         run_len = 0;
    bit         have_run = 0;
    int         busy_req_hits = 0;

    dram_rfsh_seq #(
        .PAUSE_CYC (PAUSE), .INIT_CYCLES (INIT), .RFSH_CYC (RFSH),
        .PEND_MAX (PMAX), .CSR_CYC (CSR), .RAS_CYC (RAS), .RP_CYC (RP),
        .SR_MIN_CYC (SRMIN), .SR_EXIT_CYC (SREXIT)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .grant (grant), .sleep (sleep),
        .req (req), .own (own), .busy (busy), .ras_n (ras_n),
        .cas_n (cas_n), .self_ref (self_ref)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_seg(input logic [4:0] v, input int len, input string tag);
        seg_t s;
        s.vec = v;
        s.len = len;
        s.tag = tag;
        exp_q.push_back(s);
    endtask

    task automatic emit_run();
        seg_t s;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R6 unexpected segment: actual vec %b len %0d expected none",
                     cur_vec, run_len);
        end else begin
            s = exp_q.pop_front();
            if (s.vec !== cur_vec || (s.len != 0 && s.len != run_len)) begin
                fails++;
                $display("FAIL %s segment: actual vec %b len %0d expected vec %b len %0d",
                         s.tag, cur_vec, run_len, s.vec, s.len);
            end
        end
    endtask

    task automatic push_cbr(input string tag);
        expect_seg(V_CAS, CSR, tag);
        expect_seg(V_RAS, RAS, tag);
        expect_seg(V_PRE, RP, tag);
    endtask

    task automatic push_sleep(input int hold);
        expect_seg(V_CAS, CSR, "R8");
        expect_seg(V_HOLD, hold, "R8");
        expect_seg(V_PRE, SREXIT, "R9");
        push_cbr("R9");
        expect_seg(V_IDLE, 0, "R9");
    endtask

    task automatic step();
        @(negedge clk);
        n++;
    endtask

    // monitor: run-length segments of the strobe/status vector
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && req) busy_req_hits++;
            if (!have_run) begin
                cur_vec  = {own, busy, ras_n, cas_n, self_ref};
                run_len  = 1;
                have_run = 1;
            end else if ({own, busy, ras_n, cas_n, self_ref} === cur_vec) begin
                run_len++;
            end else begin
                emit_run();
                cur_vec = {own, busy, ras_n, cas_n, self_ref};
                run_len = 1;
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYC);
        finish_run();
    end

    initial begin
        // R1: state while reset is held
        repeat (2) @(negedge clk);
        chk(busy === 1'b1 && own === 1'b1, "R1", "busy/own in reset", {busy, own}, 3);
        chk(ras_n === 1'b1 && cas_n === 1'b1, "R1", "strobes in reset", {ras_n, cas_n}, 3);
        chk(req === 1'b0 && self_ref === 1'b0, "R1", "req/self_ref in reset", {req, self_ref}, 0);

        expect_seg(V_PAUSE, PAUSE, "R1");
        for (int i = 0; i < INIT; i++) begin
            expect_seg(V_WLO, RAS, "R2");
            expect_seg(V_PAUSE, RP, "R2");
        end
        expect_seg(V_IDLE, 0, "R3");

        @(negedge clk);
        #1 rst_n = 1'b1;

        do step(); while (busy);
        n = 0;
        while (!req) step();
        chk(n == RFSH, "R4", "cycles to first owed refresh", n, RFSH);

        // R5: request waits for grant
        while (n < 2 * RFSH + 5) step();
        chk(own === 1'b0 && req === 1'b1, "R5", "own/req while ungranted", {own, req}, 1);
        chk(ras_n === 1'b1 && cas_n === 1'b1, "R5", "strobes while ungranted", {ras_n, cas_n}, 3);

        // R7: four ticks owed, saturated at PMAX, drained back to back
        for (int i = 0; i < PMAX; i++) begin
            push_cbr("R6");
            expect_seg(V_IDLE, 0, "R7");
        end
        while (n < 4 * RFSH + 1) step();
        grant = 1'b1;
        begin
            int  falls = 0;
            logic prev = 1'b0;
            while (falls < PMAX) begin
                step();
                if (prev && !own) falls++;
                prev = own;
            end
        end
        chk(req === 1'b0, "R7", "req after saturated drain", req, 0);
        grant = 1'b0;

        // R10 and R8: sleep while one refresh is owed, early drop
        push_sleep(SRMIN);
        while (!req) step();
        sleep = 1'b1;
        grant = 1'b1;
        do step(); while (!self_ref);
        repeat (2) step();
        sleep = 1'b0;
        while (own) step();
        chk(req === 1'b0, "R10", "req after exit with grant held", req, 0);

        // R8: long sleep, drop at hold sample 15
        push_sleep(15);
        sleep = 1'b1;
        do step(); while (!self_ref);
        repeat (14) step();
        sleep = 1'b0;
        while (own) step();
        repeat (3) step();
        grant = 1'b0;
        repeat (2) step();
        #1;
        emit_run();
        have_run = 0;
        chk(exp_q.size() == 0, "R9", "segments left unmatched", exp_q.size(), 0);
        chk(busy_req_hits == 0, "R3", "req samples during busy", busy_req_hits, 0);
        finish_run();
    end

endmodule